// File: doc/BRIEF.md
# Read-Cleared Interrupt Flag Controller

This block gathers single-cycle event pulses into a bank of sticky flag bits, one per event source, next to an equally wide mask register. Any flag whose mask bit is 1 pulls a registered, active-low interrupt line. If every mask bit is 0, flags still collect, so software can poll the flag bank without ever taking an interrupt.

The block sits beside a serial-bus register-access engine. It talks to that engine through strobes: one for a decoded read of the interrupt register, one for each byte the master acknowledges, and one for a mask write. Once the second byte of that read is acknowledged, the flags and all mask bits except one protected bit are cleared in a single step. Events that arrive while the read is in flight go into a pending register and reach the flags only after that clear, so none is lost.

The interrupt line stays low for at most a parameterised number of cycles. After that it is released even if flags remain set, and it is raised again only when a new enabled flag bit appears.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag bank and the mask register are all zeros and `irq_n_o` is high.
- R2: An `evt_i` bit pulsed for one cycle outside a read window sets the matching flag bit at that clock edge. The bit stays set until a clear.
- R3: A flag bit whose mask bit is 0 is visible on `flag_o` but leaves `irq_n_o` high.
- R4: When a flag bit with mask bit 1 becomes newly set, or a set flag's mask bit becomes 1, `irq_n_o` goes low at the same clock edge that updates `flag_o`/`mask_o`.
- R5: A read window opens on the cycle after `rd_open_i` is high. On the second `byte_ack_i` inside the window, the flags become 0 and every mask bit except bit `KEEP_IDX` (default bit 7) becomes 0 at that edge. The window closes and `irq_n_o` returns high.
- R6: Events arriving from the first window cycle through the clearing cycle inclusive do not appear on `flag_o` during the window. They appear on the cycle after the clear.
- R7: `irq_n_o` stays low for at most `MAX_LOW` consecutive cycles (default 20) and is then released while flags stay set. It goes low again only when a new enabled flag bit sets. An event on an already-set flag does not lower it.
- R8: A `mask_wr_i` strobe loads `mask_wdata_i` into the mask at that edge, unless it falls on the clearing cycle, where the clear wins.
- R9: A single acknowledged byte inside the window leaves flags and masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| evt_i | input | NUM_EVT | One-cycle event pulses, one bit per source |
| rd_open_i | input | 1 | Read of the interrupt register decoded (opens window) |
| byte_ack_i | input | 1 | Master acknowledged one byte of the read |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | NUM_EVT | New mask value |
| flag_o | output | NUM_EVT | Current flag bank |
| mask_o | output | NUM_EVT | Current mask register |
| irq_n_o | output | 1 | Registered active-low interrupt line |

## Verification
Several properties are checked on every cycle: flags stay sticky, no flag bit appears while the window is open, the clear leaves only the protected mask bit, a low line always has an enabled flag behind it, a new enabled bit always pulls the line low, and a counter bounds the low time. Other behaviours need ordered stimulus that only the bench scenarios provide. These are the exact low-pulse length, the line staying high when an already-set flag fires again, held events surfacing exactly one cycle after the clear, and a mask write losing to a simultaneous clear.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   // Mask of bits that survive the read clear
   function automatic logic [63:0] keep_vec(input int unsigned idx, input bit en);
      logic [63:0] v;
      v = '0;
      if (en) v[idx] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/irq_read_window.sv
module irq_read_window #(
   parameter int unsigned CLR_BYTES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_open_i,
   input  logic byte_ack_i,
   output logic win_o,
   output logic clr_o
);
   localparam int unsigned CW = (CLR_BYTES > 1) ? $clog2(CLR_BYTES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLR_BYTES - 1);

   logic          win_q;
   logic [CW-1:0] cnt_q;

   assign clr_o = win_q && byte_ack_i && (cnt_q == LAST);
   assign win_o = win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
         cnt_q <= '0;
      end else if (clr_o) begin
         win_q <= 1'b0;
         cnt_q <= '0;
      end else if (win_q) begin
         if (byte_ack_i) cnt_q <= cnt_q + 1'b1;
      end else if (rd_open_i) begin
         win_q <= 1'b1;
         cnt_q <= '0;
      end
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_EVT  = 8,
   parameter int unsigned KEEP_IDX = 7,
   parameter bit          KEEP_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               win_i,
   input  logic               clr_i,
   input  logic               mask_wr_i,
   input  logic [NUM_EVT-1:0] mask_wdata_i,
   output logic [NUM_EVT-1:0] flag_o,
   output logic [NUM_EVT-1:0] mask_o,
   output logic               arm_o,
   output logic               req_o
);
   import irq_flag_pkg::*;
   localparam logic [63:0] KEEP_ALL = keep_vec(KEEP_IDX, KEEP_EN);

   logic [NUM_EVT-1:0] flag_q, flag_d, mask_q, mask_d, pend_q, pend_d;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      if (KEEP_ALL[i]) begin : g_keep
         always_comb begin
            if (clr_i)          mask_d[i] = mask_q[i];
            else if (mask_wr_i) mask_d[i] = mask_wdata_i[i];
            else                mask_d[i] = mask_q[i];
         end
      end else begin : g_plain
         always_comb begin
            if (clr_i)          mask_d[i] = 1'b0;
            else if (mask_wr_i) mask_d[i] = mask_wdata_i[i];
            else                mask_d[i] = mask_q[i];
         end
      end

      always_comb begin
         if (clr_i) begin
            flag_d[i] = 1'b0;
            pend_d[i] = pend_q[i] | evt_i[i];
         end else if (win_i) begin
            flag_d[i] = flag_q[i];
            pend_d[i] = pend_q[i] | evt_i[i];
         end else begin
            flag_d[i] = flag_q[i] | pend_q[i] | evt_i[i];
            pend_d[i] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         mask_q <= '0;
         pend_q <= '0;
      end else begin
         flag_q <= flag_d;
         mask_q <= mask_d;
         pend_q <= pend_d;
      end
   end

   assign arm_o  = |(flag_d & mask_d & ~(flag_q & mask_q));
   assign req_o  = |(flag_d & mask_d);
   assign flag_o = flag_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/irq_low_timer.sv
module irq_low_timer #(
   parameter int unsigned MAX_LOW = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic req_i,
   output logic irq_n_o
);
   localparam int unsigned TW = $clog2(MAX_LOW + 1);
   localparam logic [TW-1:0] LAST = TW'(MAX_LOW - 1);

   logic          act_q;
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (!req_i) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (arm_i) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (act_q) begin
         if (cnt_q == LAST) begin
            act_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign irq_n_o = ~act_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
   parameter int unsigned NUM_EVT   = 8,
   parameter int unsigned KEEP_IDX  = 7,
   parameter bit          KEEP_EN   = 1'b1,
   parameter int unsigned CLR_BYTES = 2,
   parameter int unsigned MAX_LOW   = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               rd_open_i,
   input  logic               byte_ack_i,
   input  logic               mask_wr_i,
   input  logic [NUM_EVT-1:0] mask_wdata_i,
   output logic [NUM_EVT-1:0] flag_o,
   output logic [NUM_EVT-1:0] mask_o,
   output logic               irq_n_o
);
   if (NUM_EVT < 1 || NUM_EVT > 64) begin : g_bad_width
      $error("NUM_EVT must be 1..64");
   end
   if (KEEP_EN && KEEP_IDX >= NUM_EVT) begin : g_bad_keep
      $error("KEEP_IDX outside flag bank");
   end
   if (CLR_BYTES < 1) begin : g_bad_bytes
      $error("CLR_BYTES must be at least 1");
   end
   if (MAX_LOW < 1) begin : g_bad_low
      $error("MAX_LOW must be at least 1");
   end

   logic win_w, clr_w, arm_w, req_w;

   irq_read_window #(.CLR_BYTES(CLR_BYTES)) u_win (
      .clk(clk), .rst_n(rst_n), .rd_open_i(rd_open_i),
      .byte_ack_i(byte_ack_i), .win_o(win_w), .clr_o(clr_w)
   );

   irq_flag_bank #(.NUM_EVT(NUM_EVT), .KEEP_IDX(KEEP_IDX), .KEEP_EN(KEEP_EN)) u_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .win_i(win_w), .clr_i(clr_w),
      .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
      .flag_o(flag_o), .mask_o(mask_o), .arm_o(arm_w), .req_o(req_w)
   );

   irq_low_timer #(.MAX_LOW(MAX_LOW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_w), .req_i(req_w), .irq_n_o(irq_n_o)
   );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
   parameter int unsigned NUM_EVT  = 8,
   parameter int unsigned KEEP_IDX = 7,
   parameter bit          KEEP_EN  = 1'b1,
   parameter int unsigned MAX_LOW  = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               win_w,
   input logic               clr_w,
   input logic [NUM_EVT-1:0] flag_o,
   input logic [NUM_EVT-1:0] mask_o,
   input logic               irq_n_o
);
   localparam logic [NUM_EVT-1:0] KEEP = KEEP_EN ? (NUM_EVT'(1) << KEEP_IDX) : '0;

   logic [NUM_EVT-1:0] en_prev;
   int unsigned        low_cnt;
   logic               new_en;

   assign new_en = |(flag_o & mask_o & ~en_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev <= '0;
         low_cnt <= 0;
      end else begin
         en_prev <= flag_o & mask_o;
         if (irq_n_o)     low_cnt <= 0;
         else if (new_en) low_cnt <= 1;
         else             low_cnt <= low_cnt + 1;
      end
   end

   // R2
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_w |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
   // R5
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> (flag_o == '0) && ((mask_o & ~KEEP) == '0) && irq_n_o);
   // R6
   window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_w |=> ((flag_o & ~$past(flag_o)) == '0));
   // R3
   low_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_o |-> |(flag_o & mask_o));
   // R4
   new_enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_en |-> !irq_n_o);
   // R7
   max_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= MAX_LOW);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
   .NUM_EVT(NUM_EVT), .KEEP_IDX(KEEP_IDX), .KEEP_EN(KEEP_EN), .MAX_LOW(MAX_LOW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .win_w(win_w), .clr_w(clr_w),
   .flag_o(flag_o), .mask_o(mask_o), .irq_n_o(irq_n_o)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
   localparam int MAXL = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt_i = '0;
   logic       rd_open_i = 1'b0, byte_ack_i = 1'b0, mask_wr_i = 1'b0;
   logic [7:0] mask_wdata_i = '0;
   logic [7:0] flag_o, mask_o;
   logic       irq_n_o;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   irq_flag_ctrl #(.MAX_LOW(MAXL)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_open_i(rd_open_i),
      .byte_ack_i(byte_ack_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
      .flag_o(flag_o), .mask_o(mask_o), .irq_n_o(irq_n_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock with the given strobes; sample 1 ns after the edge
   task automatic step(input logic [7:0] ev, input logic rd, input logic ack,
                       input logic wr, input logic [7:0] wd);
      @(negedge clk);
      evt_i = ev; rd_open_i = rd; byte_ack_i = ack; mask_wr_i = wr; mask_wdata_i = wd;
      @(posedge clk);
      #1;
      evt_i = '0; rd_open_i = 1'b0; byte_ack_i = 1'b0; mask_wr_i = 1'b0; mask_wdata_i = '0;
   endtask

   task automatic do_read();
      step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
   endtask

   task automatic t_reset();
      chk("R1 flags", flag_o, 8'h00);
      chk("R1 mask", mask_o, 8'h00);
      chk("R1 irq", irq_n_o, 1'b1);
   endtask

   task automatic t_poll();
      step(8'h04, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R2 flag set", flag_o, 8'h04);
      chk("R3 masked irq", irq_n_o, 1'b1);
      step(8'h20, 1'b0, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R2 sticky", flag_o, 8'h24);
      chk("R3 still high", irq_n_o, 1'b1);
      do_read();
      chk("R5 flags cleared", flag_o, 8'h00);
   endtask

   task automatic t_enable_timer();
      int lows;
      step(8'h00, 1'b0, 1'b0, 1'b1, 8'h81);
      chk("R8 mask load", mask_o, 8'h81);
      chk("R8 irq high", irq_n_o, 1'b1);
      step(8'h01, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R4 irq low same edge", irq_n_o, 1'b0);
      lows = 1;
      for (int k = 0; k < MAXL + 5; k++) begin
         step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
         if (!irq_n_o) lows++;
      end
      chk("R7 low length", lows, MAXL);
      chk("R7 flag kept", flag_o, 8'h01);
      step(8'h01, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R7 no rearm on set flag", irq_n_o, 1'b1);
      step(8'h80, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R7 rearm on new bit", irq_n_o, 1'b0);
   endtask

   task automatic t_window();
      // flags 0x81, mask 0x81, irq low
      step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
      step(8'h08, 1'b0, 1'b1, 1'b0, 8'h00);
      chk("R9 flags after one ack", flag_o, 8'h81);
      chk("R9 mask after one ack", mask_o, 8'h81);
      chk("R6 held in window", flag_o & 8'h08, 8'h00);
      step(8'h10, 1'b0, 1'b1, 1'b0, 8'h00);
      chk("R5 flags zero", flag_o, 8'h00);
      chk("R5 mask keeps bit7", mask_o, 8'h80);
      chk("R5 irq high", irq_n_o, 1'b1);
      step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R6 merged after clear", flag_o, 8'h18);
      do_read();
      chk("R5 second read", flag_o, 8'h00);
   endtask

   task automatic t_wr_vs_clear();
      step(8'h00, 1'b0, 1'b0, 1'b1, 8'h0F);
      chk("R8 mask write", mask_o, 8'h0F);
      step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 1'b1, 8'hFF);
      chk("R8 clear beats write", mask_o, 8'h00);
      step(8'h40, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R3 masked after clear", irq_n_o, 1'b1);
      chk("R2 flag after clear", flag_o, 8'h40);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_poll();
      t_enable_timer();
      t_window();
      t_wr_vs_clear();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule